// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog Reset

This block is a free-running up-counter watched by four compare channels. Software programs a compare value per channel over a simple word-addressed register bus. A channel fires when the counter steps onto its compare value. Firing latches the channel's status flag. If the channel's interrupt enable was set when it fired, the channel also raises its own interrupt line, which stays high until software clears the status with a write-one-to-clear access. The counter advances once for every cycle in which the tick enable input is high, and software may overwrite it at any time.

The highest-numbered channel can also act as a watchdog. Software arms it by setting a single enable bit. Once armed, that bit cannot be cleared by software. When the watchdog channel fires while armed, the block emits a one-cycle reset request and disarms itself. Clock division down to the nominal 3.6864 MHz tick rate is done outside the block.

Top module: `ostmr_core`

## Requirements
- R1: After reset the counter, all compare values, the status flags, the interrupt enables and the watchdog enable read as zero, and every interrupt line and the reset request are low.
- R2: Each cycle with `tick_en` high and no counter write adds one to the counter. From all ones it wraps to zero.
- R3: A write to word offset 0x10 loads the counter with the written value on that clock edge. The write overrides a tick in the same cycle, and the new value reads back at 0x10.
- R4: Compare value i lives at byte offset 4*i (0x00, 0x04, 0x08, 0x0C). Status bit i, read at 0x14, is set at the edge where the counter changes to a value equal to compare i, whatever the enables are. An equality that arises without the counter changing (a compare write, or a counter write of its present value) sets nothing.
- R5: If bit i of the enable register at 0x1C is set when channel i fires, `irq_o[i]` goes high one cycle later and stays high until status bit i is cleared.
- R6: Writing 0x14 clears each status bit, and drops the matching interrupt line, for which the written data bit is 1. Bits written as 0 are left unchanged.
- R7: When a clear of status bit i and a new channel-i event fall on the same edge, the bit and its interrupt line end up set.
- R8: Writing 1 to bit 0 of offset 0x18 arms the watchdog. Writing 0 there leaves it armed. The bit reads back at 0x18 bit 0.
- R9: When channel 3 fires while the watchdog is armed, `wdt_rst_o` is high for exactly the next cycle and the watchdog enable reads 0 afterwards. When channel 3 fires unarmed, no request is made.
- R10: Reads of byte offsets at 0x20 or above return zero, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle counting enable |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | NCH | Per-channel interrupt lines |
| wdt_rst_o | output | 1 | One-cycle reset request from the watchdog |

## Verification
Two things can land on the same clock edge: a software write-one-to-clear of a status bit and a fresh compare event on that channel. The bench provokes this by loading the counter one below a compare value and then, in a single cycle, ticking while writing all ones to the status register. It expects the status bit and interrupt line to survive. The same race, together with counter writes that coincide with ticks and watchdog arming that coincides with a channel-3 event, also arises many times in the seeded random phase. There every interrupt line and the reset request are compared each cycle against a reference model kept in the bench.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
   localparam int unsigned BUS_W   = 32;
   localparam int unsigned WIN_LSB = 5;   // register window is 8 words
   // word indices (byte offset / 4); compare values occupy words 0..NCH-1
   localparam logic [2:0] W_CNT  = 3'd4;
   localparam logic [2:0] W_STAT = 3'd5;
   localparam logic [2:0] W_WDOG = 3'd6;
   localparam logic [2:0] W_IEN  = 3'd7;

   typedef struct packed {
      logic cnt;
      logic stat;
      logic wdog;
      logic ien;
   } ostmr_wr_t;
endpackage

// File: rtl/ostmr_counter.sv
module ostmr_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             cnt_chg
);
   always_comb begin
      if (load)         cnt_nxt = load_val;
      else if (tick_en) cnt_nxt = cnt_q + 1'b1;
      else              cnt_nxt = cnt_q;
   end

   assign cnt_chg = (cnt_nxt != cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/ostmr_match_ch.sv
module ostmr_match_ch #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wval,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic             cnt_chg,
   input  logic             ien,
   input  logic             clr,
   output logic [CNT_W-1:0] cmp_q,
   output logic             hit,
   output logic             stat_q,
   output logic             irq_q
);
   // event only when the counter steps onto the compare value
   assign hit = cnt_chg && (cnt_nxt == cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         stat_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (wr) cmp_q <= wval;
         if (hit)      stat_q <= 1'b1;
         else if (clr) stat_q <= 1'b0;
         if (hit && ien) irq_q <= 1'b1;
         else if (clr)   irq_q <= 1'b0;
      end
   end
endmodule

// File: rtl/ostmr_wdog.sv
module ostmr_wdog (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_wr,
   input  logic arm_bit,
   input  logic hit,
   output logic armed_q,
   output logic req_q
);
   logic fire;
   assign fire = hit && armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         req_q   <= 1'b0;
      end else begin
         req_q <= fire;
         if (fire)                  armed_q <= 1'b0;
         else if (arm_wr && arm_bit) armed_q <= 1'b1;
      end
   end
endmodule

// File: rtl/ostmr_regbus.sv
module ostmr_regbus
   import ostmr_pkg::*;
#(
   parameter int unsigned NCH    = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [NCH*CNT_W-1:0] cmp_flat,
   input  logic [CNT_W-1:0]     cnt_q,
   input  logic [NCH-1:0]       stat_q,
   input  logic                 wdog_q,
   input  logic [NCH-1:0]       ien_q,
   output logic [NCH-1:0]       wr_cmp,
   output ostmr_wr_t            wr_s,
   output logic [BUS_W-1:0]     bus_rdata
);
   logic       in_win;
   logic [2:0] word;
   logic [1:0] unused_lo;

   assign in_win    = (bus_addr[ADDR_W-1:WIN_LSB] == '0);
   assign word      = bus_addr[WIN_LSB-1:2];
   assign unused_lo = bus_addr[1:0];

   genvar gi;
   generate
      for (gi = 0; gi < NCH; gi++) begin : g_wdec
         assign wr_cmp[gi] = bus_wr && in_win && (word == 3'(gi));
      end
   endgenerate

   assign wr_s.cnt  = bus_wr && in_win && (word == W_CNT);
   assign wr_s.stat = bus_wr && in_win && (word == W_STAT);
   assign wr_s.wdog = bus_wr && in_win && (word == W_WDOG);
   assign wr_s.ien  = bus_wr && in_win && (word == W_IEN);

   always_comb begin
      bus_rdata = '0;
      if (in_win) begin
         unique case (word)
            W_CNT:  bus_rdata[CNT_W-1:0] = cnt_q;
            W_STAT: bus_rdata[NCH-1:0]   = stat_q;
            W_WDOG: bus_rdata[0]         = wdog_q;
            W_IEN:  bus_rdata[NCH-1:0]   = ien_q;
            default: begin
               if (int'(word) < NCH)
                  bus_rdata[CNT_W-1:0] = cmp_flat[int'(word)*CNT_W +: CNT_W];
            end
         endcase
      end
   end
endmodule

// File: rtl/ostmr_core.sv
module ostmr_core
   import ostmr_pkg::*;
#(
   parameter int unsigned NCH     = 4,
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned ADDR_W  = 8,
   parameter bit          WDOG_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NCH-1:0]    irq_o,
   output logic              wdt_rst_o
);
   localparam int unsigned WD_CH = NCH - 1;

   generate
      if (NCH < 1 || NCH > 4) begin : g_bad_nch
         $error("ostmr_core: NCH must be 1..4");
      end
      if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cw
         $error("ostmr_core: CNT_W must be 2..32");
      end
      if (ADDR_W <= WIN_LSB) begin : g_bad_aw
         $error("ostmr_core: ADDR_W too small");
      end
   endgenerate

   logic [CNT_W-1:0]     cnt_q, cnt_nxt;
   logic                 cnt_chg;
   logic [NCH*CNT_W-1:0] cmp_flat;
   logic [NCH-1:0]       wr_cmp, hit, stat_q, ien_q;
   logic                 wdog_q;
   ostmr_wr_t            wr_s;

   ostmr_regbus #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_bus (
      .bus_wr(bus_wr), .bus_addr(bus_addr), .cmp_flat(cmp_flat),
      .cnt_q(cnt_q), .stat_q(stat_q), .wdog_q(wdog_q), .ien_q(ien_q),
      .wr_cmp(wr_cmp), .wr_s(wr_s), .bus_rdata(bus_rdata)
   );

   ostmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load(wr_s.cnt),
      .load_val(bus_wdata[CNT_W-1:0]), .cnt_q(cnt_q),
      .cnt_nxt(cnt_nxt), .cnt_chg(cnt_chg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ien_q <= '0;
      else if (wr_s.ien) ien_q <= bus_wdata[NCH-1:0];
   end

   genvar gi;
   generate
      for (gi = 0; gi < NCH; gi++) begin : g_ch
         ostmr_match_ch #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .wr(wr_cmp[gi]),
            .wval(bus_wdata[CNT_W-1:0]), .cnt_nxt(cnt_nxt),
            .cnt_chg(cnt_chg), .ien(ien_q[gi]),
            .clr(wr_s.stat && bus_wdata[gi]),
            .cmp_q(cmp_flat[gi*CNT_W +: CNT_W]), .hit(hit[gi]),
            .stat_q(stat_q[gi]), .irq_q(irq_o[gi])
         );
      end

      if (WDOG_EN) begin : g_wdog
         ostmr_wdog u_wdog (
            .clk(clk), .rst_n(rst_n), .arm_wr(wr_s.wdog),
            .arm_bit(bus_wdata[0]), .hit(hit[WD_CH]),
            .armed_q(wdog_q), .req_q(wdt_rst_o)
         );
      end else begin : g_no_wdog
         assign wdog_q    = 1'b0;
         assign wdt_rst_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/ostmr_core_chk.sv
module ostmr_core_chk #(
   parameter int unsigned NCH    = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [NCH-1:0]    irq_o,
   input logic              wdt_rst_o,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [NCH-1:0]    stat_q,
   input logic              wdog_q
);
   logic in_win, ld, sclr;
   assign in_win = (bus_addr[ADDR_W-1:5] == '0);
   assign ld     = bus_wr && in_win && (bus_addr[4:2] == 3'd4);
   assign sclr   = bus_wr && in_win && (bus_addr[4:2] == 3'd5);

   a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !ld) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cnt_q == $past(bus_wdata[CNT_W-1:0])));

   genvar gi;
   generate
      for (gi = 0; gi < NCH; gi++) begin : g_irq
         a_r5_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_o[gi] && !(sclr && bus_wdata[gi])) |=> irq_o[gi]);
         a_r5_irq_has_status: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[gi] |-> stat_q[gi]);
      end
   endgenerate

   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_o |=> !wdt_rst_o);

   a_r9_pulse_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_o |-> ($past(wdog_q) && !wdog_q));

   a_r8_only_fire_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdog_q) |-> wdt_rst_o);
endmodule

bind ostmr_core ostmr_core_chk #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_o(irq_o),
   .wdt_rst_o(wdt_rst_o), .cnt_q(cnt_q), .stat_q(stat_q), .wdog_q(wdog_q)
);

// File: tb/ostmr_core_tb.sv
`timescale 1ns/1ps
module ostmr_core_tb;
   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  irq_o;
   logic        wdt_rst_o;

   int n_checks = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   ostmr_core u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
   );

   // reference model state
   logic [31:0] m_cnt;
   logic [31:0] m_cmp [4];
   logic [3:0]  m_stat, m_irq, m_ien;
   logic        m_wd, m_rst;

   function automatic logic [31:0] m_read(input logic [7:0] a);
      if (a >= 8'h20) return 32'h0;
      case (a[4:2])
         3'd4: return m_cnt;
         3'd5: return {28'h0, m_stat};
         3'd6: return {31'h0, m_wd};
         3'd7: return {28'h0, m_ien};
         default: return m_cmp[a[3:2]];
      endcase
   endfunction

   task automatic model_edge(input logic t, input logic w,
                             input logic [7:0] a, input logic [31:0] d);
      logic        win;
      logic [31:0] cn;
      logic        chg;
      logic [3:0]  h;
      logic        fire;
      win = w && (a < 8'h20);
      cn  = (win && a[4:2] == 3'd4) ? d : (t ? m_cnt + 1 : m_cnt);
      chg = (cn != m_cnt);
      for (int i = 0; i < NCH; i++) h[i] = chg && (cn == m_cmp[i]);
      fire = h[3] && m_wd;
      for (int i = 0; i < NCH; i++) begin
         logic clr;
         clr = win && a[4:2] == 3'd5 && d[i];
         if (h[i]) m_stat[i] = 1'b1; else if (clr) m_stat[i] = 1'b0;
         if (h[i] && m_ien[i]) m_irq[i] = 1'b1; else if (clr) m_irq[i] = 1'b0;
         if (win && a[4:2] == 3'(i)) m_cmp[i] = d;
      end
      if (win && a[4:2] == 3'd7) m_ien = d[3:0];
      if (fire) m_wd = 1'b0;
      else if (win && a[4:2] == 3'd6 && d[0]) m_wd = 1'b1;
      m_rst = fire;
      m_cnt = cn;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one clock: drive at negedge, model at edge, compare at next negedge
   task automatic step(input logic t, input logic w, input logic [7:0] a,
                       input logic [31:0] d);
      tick_en = t; bus_wr = w; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      model_edge(t, w, a, d);
      @(negedge clk);
      chk("R5 irq lines", {28'h0, irq_o}, {28'h0, m_irq});
      chk("R9 reset request", {31'h0, wdt_rst_o}, {31'h0, m_rst});
      bus_wr = 1'b0; tick_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      bus_wr = 1'b0; bus_addr = a; #1;
      chk(tag, bus_rdata, m_read(a));
   endtask

   task automatic rd_lit(input logic [7:0] a, input logic [31:0] exp, input string tag);
      bus_wr = 1'b0; bus_addr = a; #1;
      chk(tag, bus_rdata, exp);
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0A17));
      m_cnt = 0; m_stat = 0; m_irq = 0; m_ien = 0; m_wd = 0; m_rst = 0;
      for (int i = 0; i < 4; i++) m_cmp[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int i = 0; i < 8; i++) rd_lit(8'(i*4), 32'h0, "R1 reset register");
      chk("R1 reset irq", {28'h0, irq_o}, 32'h0);
      chk("R1 reset request", {31'h0, wdt_rst_o}, 32'h0);

      // R4/R5 basic match with enable
      step(0, 1, 8'h00, 32'd3);
      step(0, 1, 8'h1C, 32'h1);
      step(1, 0, 0, 0); step(1, 0, 0, 0); step(1, 0, 0, 0);
      chk("R5 irq0 after match", {31'h0, irq_o[0]}, 32'h1);
      rd_lit(8'h14, 32'h1, "R4 status after match");
      repeat (3) step(0, 0, 0, 0);
      chk("R5 irq0 held", {31'h0, irq_o[0]}, 32'h1);

      // R6 write-one-to-clear
      step(0, 1, 8'h14, 32'h0);
      rd_lit(8'h14, 32'h1, "R6 zero bits keep status");
      step(0, 1, 8'h14, 32'h1);
      rd_lit(8'h14, 32'h0, "R6 status cleared");
      chk("R6 irq0 dropped", {31'h0, irq_o[0]}, 32'h0);

      // R4 stationary equality raises nothing
      step(0, 1, 8'h04, 32'd3);
      step(0, 1, 8'h10, 32'd3);
      rd_lit(8'h14, 32'h0, "R4 stationary equality");

      // R3 load beats tick
      step(1, 1, 8'h10, 32'd100);
      rd_lit(8'h10, 32'd100, "R3 load overrides tick");

      // R7 clear and event on the same edge
      step(0, 1, 8'h08, 32'd105);
      step(0, 1, 8'h10, 32'd104);
      step(1, 1, 8'h14, 32'hF);
      rd_lit(8'h14, 32'h4, "R7 set wins over clear");

      // R8 arming cannot be undone by software
      step(0, 1, 8'h18, 32'h1);
      step(0, 1, 8'h18, 32'h0);
      rd_lit(8'h18, 32'h1, "R8 watchdog stays armed");

      // R9 armed fire
      step(0, 1, 8'h0C, 32'd200);
      step(0, 1, 8'h10, 32'd199);
      step(1, 0, 0, 0);
      chk("R9 pulse on armed match", {31'h0, wdt_rst_o}, 32'h1);
      step(0, 0, 0, 0);
      chk("R9 pulse one cycle", {31'h0, wdt_rst_o}, 32'h0);
      rd_lit(8'h18, 32'h0, "R9 watchdog disarmed");

      // R9 unarmed match: no request
      step(0, 1, 8'h10, 32'd199);
      step(1, 0, 0, 0);
      chk("R9 no pulse unarmed", {31'h0, wdt_rst_o}, 32'h0);
      rd(8'h14, "R9 status bit 3 set unarmed");

      // R2 wrap
      step(0, 1, 8'h10, 32'hFFFF_FFFF);
      step(1, 0, 0, 0);
      rd_lit(8'h10, 32'h0, "R2 counter wraps");

      // R10 outside the window
      step(0, 1, 8'h24, 32'hDEAD_BEEF);
      rd_lit(8'h24, 32'h0, "R10 unmapped read");
      rd_lit(8'h08, 32'd105, "R10 compare untouched");
      for (int i = 0; i < 8; i++) rd(8'(i*4), "R10 window after stray write");

      // seeded random phase against the reference model
      for (int n = 0; n < 4000; n++) begin
         logic        t, w;
         logic [7:0]  a;
         logic [31:0] d;
         int          k;
         t = ($urandom % 3) != 0;
         w = ($urandom % 4) == 0;
         k = $urandom % 9;
         a = (k == 8) ? 8'h20 : 8'(k * 4);
         case (k)
            0, 1, 2, 3: d = m_cnt + ($urandom % 8);
            4: d = (($urandom % 4) == 0) ? $urandom : m_cnt + ($urandom % 3);
            default: d = $urandom;
         endcase
         step(t, w, a, d);
         if (n % 8 == 0) rd(8'(($urandom % 9) * 4), "R4 random register read");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule